// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block keeps wall-clock time: seconds, minutes, hours, day of week, day of month, month, and a two-digit year counted from a base year parameter. Each one-second tick advances the time by one second. Every carry propagates in the same clock cycle, and the block applies month lengths and the Gregorian leap-year rule. Internally the time is kept in plain binary. The host sees each field through a byte port. A mode input picks BCD or binary encoding, and a second mode input picks 24-hour or 12-hour display. In 12-hour display, bit 7 of the hour byte marks PM.

To change the time, the host raises the hold input, writes the fields it wants, and drops the hold. While hold is low, a shadow byte bank follows the live time in the current display encoding. Fields the host does not write therefore keep their values. On the falling edge of hold, the whole bank is decoded under the current modes and loaded into the counter. Ticks count only when the oscillator-control field equals 3'b010. Ticks are also ignored while hold is high.

Top module: `tod_calendar`

## Requirements
- R1: On a counting tick, seconds at 59 wrap to 0 and advance minutes; minutes at 59 wrap to 0 and advance hours.
- R2: When hours wrap from 23 to 0, the same tick advances both day of week and day of month.
- R3: Day of week runs 1..7 and goes from 7 to 1 at a day boundary.
- R4: Months have 31,28,31,30,31,30,31,31,30,31,30,31 days. Past the last day, the day of month goes to 1 and the month advances. Month 12 wraps to 1 and advances the year.
- R5: February has 29 days when the full year (BASE_YEAR plus the two-digit year) is divisible by 4 and is either not divisible by 100 or divisible by 400.
- R6: The two-digit year wraps from 99 to 0.
- R7: With bin_mode_i=0, each byte is BCD: tens in bits 7:4 and units in bits 3:0. With bin_mode_i=1, each byte is the plain binary value. Reads and loads both follow this setting.
- R8: With hr24_mode_i=0, the hour byte holds the 12-hour value (1..12, where hour 0 shows as 12) in bits 6:0 and the PM flag (hours 12..23) in bit 7. Going from 11 to 12 toggles the flag.
- R9: A tick advances the time only when osc_ctl_i equals 3'b010. Any other value leaves all fields unchanged.
- R10: While set_i is high, ticks have no effect. Writes land in the shadow bank only while set_i is high. On the falling edge of set_i, the bank is decoded under the current modes and loaded. A hold pulse with no writes leaves the time unchanged.
- R11: After reset, the time reads 00:00:00, day of week 1, day 1, month 1, year 0.
- R12: Field selects are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year. Select 7 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse once per second |
| osc_ctl_i | input | 3 | Oscillator-control field; counting needs 3'b010 |
| bin_mode_i | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| hr24_mode_i | input | 1 | 1 = 24-hour hour byte, 0 = 12-hour with PM in bit 7 |
| set_i | input | 1 | Hold: freezes counting, opens writes, loads on fall |
| wr_en_i | input | 1 | Write strobe for the shadow bank |
| wr_sel_i | input | 3 | Field select for writes |
| wr_data_i | input | 8 | Write byte |
| rd_sel_i | input | 3 | Field select for reads |
| rd_data_o | output | 8 | Selected live field in the current encoding |

## Verification
A wrong carry shows up on the read port one cycle after the tick that crosses a boundary. Examples are a skipped leap day, a day-of-week value of 0 or 8, and a year that does not reset at 99. The bench therefore places the time just before each boundary and reads the fields right after a single tick. Format faults appear without any tick, as soon as the field is read under a different mode. Examples are a PM bit on the wrong side of noon, or 12-hour midnight shown as 0. Load faults appear on the first read after hold drops, because unwritten fields must come back exactly as they were.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int NUM_FIELDS = 7;
  localparam int BYTE_W     = 8;
  localparam int SEL_W      = $clog2(NUM_FIELDS + 1);

  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_DOW  = 3;
  localparam int IDX_DOM  = 4;
  localparam int IDX_MON  = 5;
  localparam int IDX_YEAR = 6;

  localparam logic [2:0] OSC_RUN = 3'b010;

  typedef struct packed {
    logic [6:0] yr;
    logic [3:0] mon;
    logic [4:0] dom;
    logic [2:0] dow;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } tod_t;

  localparam tod_t TOD_RESET = '{yr: 7'd0, mon: 4'd1, dom: 5'd1, dow: 3'd1,
                                 hour: 5'd0, min: 6'd0, sec: 6'd0};

  function automatic logic [7:0] bin_to_bcd(input logic [6:0] v);
    logic [6:0] tens, units;
    tens  = v / 7'd10;
    units = v % 7'd10;
    return {tens[3:0], units[3:0]};
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic [7:0] encode(input logic [6:0] v, input logic bin);
    return bin ? {1'b0, v} : bin_to_bcd(v);
  endfunction

  function automatic logic [6:0] decode(input logic [7:0] b, input logic bin);
    return bin ? b[6:0] : bcd_to_bin(b);
  endfunction

  // 12-hour view: hour 0 shows as 12, bit 7 flags the afternoon
  function automatic logic [7:0] encode_hour(input logic [4:0] h, input logic bin,
                                             input logic h24);
    logic [4:0] h12;
    logic [7:0] e;
    if (h24) return encode({2'b00, h}, bin);
    h12 = (h >= 5'd12) ? h - 5'd12 : h;
    if (h12 == 5'd0) h12 = 5'd12;
    e = encode({2'b00, h12}, bin);
    return {(h >= 5'd12), e[6:0]};
  endfunction

  function automatic logic [4:0] decode_hour(input logic [7:0] b, input logic bin,
                                             input logic h24);
    logic [6:0] v;
    logic [4:0] h;
    if (h24) begin
      v = decode(b, bin);
      return v[4:0];
    end
    v = decode({1'b0, b[6:0]}, bin);
    h = (v == 7'd12) ? 5'd0 : v[4:0];
    return b[7] ? h + 5'd12 : h;
  endfunction

  function automatic logic is_leap(input int unsigned year);
    return (year % 4 == 0) && ((year % 100 != 0) || (year % 400 == 0));
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] mon, input logic leap);
    case (mon)
      4'd2:                    return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      default:                 return 5'd31;
    endcase
  endfunction

  function automatic logic [6:0] field_get(input tod_t t, input int idx);
    case (idx)
      IDX_SEC:  return 7'(t.sec);
      IDX_MIN:  return 7'(t.min);
      IDX_HOUR: return 7'(t.hour);
      IDX_DOW:  return 7'(t.dow);
      IDX_DOM:  return 7'(t.dom);
      IDX_MON:  return 7'(t.mon);
      default:  return t.yr;
    endcase
  endfunction
endpackage

// File: rtl/tod_step.sv
module tod_step
  import tod_pkg::*;
#(
  parameter int unsigned BASE_YEAR = 2000
) (
  input  tod_t cur_i,
  output tod_t nxt_o,
  output logic sec_wrap_o,
  output logic min_wrap_o,
  output logic day_wrap_o,
  output logic mon_wrap_o,
  output logic year_wrap_o,
  output logic cent_wrap_o
);
  logic       leap;
  logic [4:0] dim;

  assign leap = is_leap(BASE_YEAR + 32'(cur_i.yr));
  assign dim  = month_days(cur_i.mon, leap);

  assign sec_wrap_o  = cur_i.sec >= 6'd59;
  assign min_wrap_o  = sec_wrap_o && (cur_i.min >= 6'd59);
  assign day_wrap_o  = min_wrap_o && (cur_i.hour >= 5'd23);
  assign mon_wrap_o  = day_wrap_o && (cur_i.dom >= dim);
  assign year_wrap_o = mon_wrap_o && (cur_i.mon >= 4'd12);
  assign cent_wrap_o = year_wrap_o && (cur_i.yr >= 7'd99);

  always_comb begin
    nxt_o     = cur_i;
    nxt_o.sec = sec_wrap_o ? 6'd0 : cur_i.sec + 6'd1;
    if (sec_wrap_o) nxt_o.min  = min_wrap_o ? 6'd0 : cur_i.min + 6'd1;
    if (min_wrap_o) nxt_o.hour = day_wrap_o ? 5'd0 : cur_i.hour + 5'd1;
    if (day_wrap_o) begin
      nxt_o.dow = (cur_i.dow >= 3'd7) ? 3'd1 : cur_i.dow + 3'd1;
      nxt_o.dom = mon_wrap_o ? 5'd1 : cur_i.dom + 5'd1;
    end
    if (mon_wrap_o)  nxt_o.mon = year_wrap_o ? 4'd1 : cur_i.mon + 4'd1;
    if (year_wrap_o) nxt_o.yr  = cent_wrap_o ? 7'd0 : cur_i.yr + 7'd1;
  end
endmodule

// File: rtl/tod_encode.sv
module tod_encode
  import tod_pkg::*;
(
  input  tod_t                                   tod_i,
  input  logic                                   bin_i,
  input  logic                                   h24_i,
  output logic [NUM_FIELDS-1:0][BYTE_W-1:0]      bytes_o
);
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    if (g == IDX_HOUR) begin : g_hour
      assign bytes_o[g] = encode_hour(tod_i.hour, bin_i, h24_i);
    end else begin : g_plain
      assign bytes_o[g] = encode(field_get(tod_i, g), bin_i);
    end
  end
endmodule

// File: rtl/tod_decode.sv
module tod_decode
  import tod_pkg::*;
(
  input  logic [NUM_FIELDS-1:0][BYTE_W-1:0] bytes_i,
  input  logic                              bin_i,
  input  logic                              h24_i,
  output tod_t                              tod_o
);
  logic [NUM_FIELDS-1:0][6:0] plain;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    assign plain[g] = decode(bytes_i[g], bin_i);
  end

  always_comb begin
    tod_o.sec  = plain[IDX_SEC][5:0];
    tod_o.min  = plain[IDX_MIN][5:0];
    tod_o.hour = decode_hour(bytes_i[IDX_HOUR], bin_i, h24_i);
    tod_o.dow  = plain[IDX_DOW][2:0];
    tod_o.dom  = plain[IDX_DOM][4:0];
    tod_o.mon  = plain[IDX_MON][3:0];
    tod_o.yr   = plain[IDX_YEAR];
  end
endmodule

// File: rtl/tod_calendar.sv
module tod_calendar
  import tod_pkg::*;
#(
  parameter int unsigned BASE_YEAR = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [2:0]        osc_ctl_i,
  input  logic              bin_mode_i,
  input  logic              hr24_mode_i,
  input  logic              set_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  tod_t tod_q, tod_nxt, tod_load;
  logic set_q;
  logic [NUM_FIELDS-1:0][BYTE_W-1:0] shadow_q, enc_bytes;

  // named events for the assertions
  logic set_fall, adv_en;
  logic sec_wrap, min_wrap, day_wrap, mon_wrap, year_wrap, cent_wrap;

  assign set_fall = set_q && !set_i;
  assign adv_en   = tick_i && (osc_ctl_i == OSC_RUN) && !set_i && !set_fall;

  tod_step #(.BASE_YEAR(BASE_YEAR)) u_step (
    .cur_i(tod_q), .nxt_o(tod_nxt),
    .sec_wrap_o(sec_wrap), .min_wrap_o(min_wrap), .day_wrap_o(day_wrap),
    .mon_wrap_o(mon_wrap), .year_wrap_o(year_wrap), .cent_wrap_o(cent_wrap)
  );

  tod_encode u_enc (
    .tod_i(tod_q), .bin_i(bin_mode_i), .h24_i(hr24_mode_i), .bytes_o(enc_bytes)
  );

  tod_decode u_dec (
    .bytes_i(shadow_q), .bin_i(bin_mode_i), .h24_i(hr24_mode_i), .tod_o(tod_load)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tod_q    <= TOD_RESET;
      set_q    <= 1'b0;
      shadow_q <= '0;
    end else begin
      set_q <= set_i;
      if (set_fall)    tod_q <= tod_load;
      else if (adv_en) tod_q <= tod_nxt;
      for (int i = 0; i < NUM_FIELDS; i++) begin
        if (set_i) begin
          if (wr_en_i && wr_sel_i == SEL_W'(i)) shadow_q[i] <= wr_data_i;
        end else begin
          shadow_q[i] <= enc_bytes[i];
        end
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (rd_sel_i == SEL_W'(i)) rd_data_o = enc_bytes[i];
  end

  // R1: seconds wrap on a counting tick
  p_sec_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    adv_en && sec_wrap |=> tod_q.sec == 6'd0);

  // R2: day boundary brings hours to 0 and moves day of month
  p_day_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adv_en && day_wrap |=> tod_q.hour == 5'd0 && tod_q.dom != $past(tod_q.dom));

  // R3: day of week wraps 7 -> 1
  p_dow_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adv_en && day_wrap && tod_q.dow == 3'd7 |=> tod_q.dow == 3'd1);

  // R6: year wraps 99 -> 0
  p_year_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adv_en && cent_wrap |=> tod_q.yr == 7'd0);

  // R9: stopped oscillator field leaves time unchanged
  p_osc_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && osc_ctl_i != OSC_RUN && !set_fall |=> $stable(tod_q));

  // R10: hold freezes the time
  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> $stable(tod_q));
endmodule

// File: tb/tod_calendar_bench.sv
module tod_calendar_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic [2:0] osc_ctl_i = 3'b010;
  logic       bin_mode_i = 1'b0;
  logic       hr24_mode_i = 1'b1;
  logic       set_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_sel_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [2:0] rd_sel_i = '0;
  logic [7:0] rd_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [2:0] sel;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  tod_calendar u_tod_calendar (
    .clk, .rst_n, .tick_i, .osc_ctl_i, .bin_mode_i, .hr24_mode_i, .set_i,
    .wr_en_i, .wr_sel_i, .wr_data_i, .rd_sel_i, .rd_data_o
  );

  // monitor: pops expectations and compares at the read port
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      rd_sel_i = it.sel;
      #1;
      checks++;
      if (rd_data_o !== it.exp) begin
        errors++;
        $display("FAIL %s field=%0d actual=%02h expected=%02h", it.tag, it.sel,
                 rd_data_o, it.exp);
      end
    end
  end

  task automatic expect_fld(input logic [2:0] sel, input logic [7:0] exp, input string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    wait (sb.size() == 0);
    #2;
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic do_tick();
    cyc(); tick_i = 1'b1;
    cyc(); tick_i = 1'b0;
  endtask

  task automatic set_mode(input logic bin, input logic h24);
    cyc(); bin_mode_i = bin; hr24_mode_i = h24;
    cyc(); cyc();
  endtask

  task automatic load_time(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                           input logic [7:0] dw, input logic [7:0] dm, input logic [7:0] mo,
                           input logic [7:0] y);
    logic [7:0] v [7];
    v = '{s, mi, h, dw, dm, mo, y};
    cyc(); set_i = 1'b1;
    for (int i = 0; i < 7; i++) begin
      cyc(); wr_en_i = 1'b1; wr_sel_i = 3'(i); wr_data_i = v[i];
    end
    cyc(); wr_en_i = 1'b0; set_i = 1'b0;
    cyc(); cyc();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    // R11 reset state
    expect_fld(0, 8'h00, "R11 sec");
    expect_fld(2, 8'h00, "R11 hour");
    expect_fld(3, 8'h01, "R11 dow");
    expect_fld(4, 8'h01, "R11 dom");
    expect_fld(5, 8'h01, "R11 mon");
    expect_fld(6, 8'h00, "R11 year");
    expect_fld(7, 8'h00, "R12 unused select");

    // full rollover: 99-12-31 23:59:59, dow 7
    load_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    expect_fld(0, 8'h59, "R10 load sec");
    expect_fld(2, 8'h23, "R10 load hour");
    do_tick();
    expect_fld(0, 8'h00, "R1 sec wrap");
    expect_fld(1, 8'h00, "R1 min wrap");
    expect_fld(2, 8'h00, "R2 hour wrap");
    expect_fld(3, 8'h01, "R3 dow 7->1");
    expect_fld(4, 8'h01, "R4 dom wrap");
    expect_fld(5, 8'h01, "R4 month 12->1");
    expect_fld(6, 8'h00, "R6 year 99->0");

    // plain minute carry, no hour carry
    load_time(8'h59, 8'h14, 8'h08, 8'h02, 8'h10, 8'h05, 8'h30);
    do_tick();
    expect_fld(1, 8'h15, "R1 minute advance");
    expect_fld(2, 8'h08, "R1 hour unchanged");

    // leap years: 2024 and 2000
    load_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
    do_tick();
    expect_fld(4, 8'h29, "R5 2024 feb 29");
    expect_fld(5, 8'h02, "R5 2024 still feb");
    expect_fld(3, 8'h04, "R2 dow advance");
    load_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h24);
    do_tick();
    expect_fld(4, 8'h01, "R5 2024 feb 29 -> mar 1");
    expect_fld(5, 8'h03, "R5 march");
    load_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h00);
    do_tick();
    expect_fld(4, 8'h29, "R5 2000 leap");
    load_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23);
    do_tick();
    expect_fld(4, 8'h01, "R5 2023 not leap");
    expect_fld(5, 8'h03, "R5 2023 march");

    // 30-day month
    load_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h04, 8'h10);
    do_tick();
    expect_fld(4, 8'h01, "R4 april 30 wrap");
    expect_fld(5, 8'h05, "R4 may");
    expect_fld(6, 8'h10, "R4 year unchanged");

    // 12-hour display
    load_time(8'h00, 8'h05, 8'h13, 8'h01, 8'h15, 8'h06, 8'h24);
    set_mode(1'b0, 1'b0);
    expect_fld(2, 8'h81, "R8 13h shows PM 1");
    load_time(8'h59, 8'h59, 8'h11, 8'h03, 8'h15, 8'h06, 8'h24);
    do_tick();
    expect_fld(2, 8'h92, "R8 11AM -> 12PM");
    load_time(8'h59, 8'h59, 8'h91, 8'h03, 8'h15, 8'h06, 8'h24);
    do_tick();
    expect_fld(2, 8'h12, "R8 11PM -> 12AM");
    expect_fld(4, 8'h16, "R2 dom after midnight");
    set_mode(1'b0, 1'b1);
    expect_fld(2, 8'h00, "R8 midnight in 24h");

    // binary encoding
    set_mode(1'b1, 1'b1);
    expect_fld(4, 8'h10, "R7 dom 16 binary");
    load_time(8'h3B, 8'h14, 8'h0A, 8'h02, 8'h05, 8'h03, 8'h18);
    do_tick();
    expect_fld(0, 8'h00, "R7 binary sec wrap");
    expect_fld(1, 8'h15, "R7 binary min 21");
    set_mode(1'b0, 1'b1);
    expect_fld(1, 8'h21, "R7 bcd min 21");
    expect_fld(6, 8'h24, "R7 bcd year 24");

    // oscillator gate
    cyc(); osc_ctl_i = 3'b000;
    do_tick();
    expect_fld(0, 8'h00, "R9 tick ignored osc 000");
    cyc(); osc_ctl_i = 3'b110;
    do_tick();
    expect_fld(0, 8'h00, "R9 tick ignored osc 110");
    cyc(); osc_ctl_i = 3'b010;
    do_tick();
    expect_fld(0, 8'h01, "R9 tick counts osc 010");

    // hold freezes, writes without hold ignored, empty hold keeps time
    cyc(); set_i = 1'b1;
    do_tick();
    cyc(); set_i = 1'b0;
    cyc(); cyc();
    expect_fld(0, 8'h01, "R10 frozen under hold");
    expect_fld(1, 8'h21, "R10 empty hold keeps min");
    cyc(); wr_en_i = 1'b1; wr_sel_i = 3'd0; wr_data_i = 8'h45;
    cyc(); wr_en_i = 1'b0;
    cyc(); set_i = 1'b1;
    cyc(); cyc(); set_i = 1'b0;
    cyc(); cyc();
    expect_fld(0, 8'h01, "R10 write without hold ignored");
    // write to select 7 ignored
    cyc(); set_i = 1'b1;
    cyc(); wr_en_i = 1'b1; wr_sel_i = 3'd7; wr_data_i = 8'h33;
    cyc(); wr_en_i = 1'b0; set_i = 1'b0;
    cyc(); cyc();
    expect_fld(7, 8'h00, "R12 select 7 reads 0");
    expect_fld(0, 8'h01, "R12 select 7 write no effect");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule